// File: doc/BRIEF.md
# Command-Stepped I2C Bus Master

This block is an I2C bus master that software drives one bus step at a time through a small register port. A step is a START or repeated START, sending one byte and sampling the acknowledge bit, receiving one byte and returning a chosen acknowledge, or a STOP. Every step except STOP ends by raising a done flag and posting a fixed 8-bit outcome code in a status register. The engine then parks the bus with SCL held low. It stays there until software writes the control register with the done bit at zero. That write both clears the flag and launches whatever the control bits and the data register now ask for.

SCL and SDA are open-drain. An output enable high pulls the line low, and the block reads the resolved line levels back on `scl_in` and `sda_in`. The bit rate comes from a one-cycle `tick` supplied by an external rate generator, and each bit takes four ticks. A baud register and an own-address register are kept as plain storage. Their values are returned to defaults by a soft reset.

Top module: `i2c_step_master`

## Requirements
- R1: After reset the status register (offset 3) reads 0xF8, the control register (offset 2) reads 0x00, the baud register (offset 4) reads 0x44, the own-address register (offset 0) reads 0x00, both line enables are low and `irq` is low. The data register sits at offset 1 and the soft-reset register at offset 5.
- R2: Control bit 5 requests a START. The result is status 0x08 when the bus was free and 0x10 when this master already owned the bus. A START request takes priority over the byte launch made by the same control write.
- R3: An address byte (the first byte after a START, bit 0 = direction, 1 = read) ends with status 0x18 (write, ACK), 0x20 (write, NAK), 0x40 (read, ACK) or 0x48 (read, NAK).
- R4: A later transmitted byte ends with 0x28 when it is ACKed and 0x30 when it is NAKed. Bytes go out MSB first.
- R5: A receive step is launched when the last status was 0x40 or 0x50. The master returns ACK when control bit 2 was set at launch, giving status 0x50, and NAK otherwise, giving 0x58. The byte, MSB first, then reads back from the data register.
- R6: Control bit 3 is the done flag. It rises only together with a status other than 0xF8. Writing control with bit 3 = 0 clears it and launches the next step. Writing 1 leaves it set and launches nothing. While the flag is set, SCL and SDA hold their levels.
- R7: Control bit 4 requests a STOP. The STOP never sets the done flag, and the status becomes 0xF8 only once SCL and SDA both read high.
- R8: `irq` is high exactly when the done flag and control bit 7 (interrupt enable) are both set.
- R9: While control bit 6 (enable) is 0, no step starts and both lines stay released.
- R10: Any write to offset 5 returns the engine to idle, releases both lines, and restores status 0xF8, control 0x00, baud 0x44 and own address 0x00.
- R11: SDA changes while SCL is released only to form a START (falling) or a STOP (rising). Data bits change while SCL is low.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| tick | input | 1 | One-cycle quarter-bit enable from the rate generator |
| reg_addr | input | 3 | Register offset |
| reg_we | input | 1 | Register write strobe |
| reg_wdata | input | 8 | Register write data |
| reg_rdata | output | 8 | Register read data (combinational) |
| scl_in | input | 1 | Resolved SCL level |
| sda_in | input | 1 | Resolved SDA level |
| scl_oe | output | 1 | Pull SCL low when high |
| sda_oe | output | 1 | Pull SDA low when high |
| irq | output | 1 | Done flag gated by interrupt enable |

## Verification
The byte launch and a START request can fall in the same control write. Clearing the done flag after a byte while also setting the START bit would otherwise start a transfer of the data register. The stimulus table provokes this twice, once after a written data byte and once after an address byte that was NAKed. The step is judged correct when the status reads 0x10, when a bus-level slave model then decodes the following byte as a fresh address, and when the count of START edges seen on the wires matches the table.

// File: rtl/i2c_step_master.sv
module i2c_step_master #(
  parameter logic [7:0] BAUD_RST = 8'h44,
  parameter logic [7:0] OWN_RST  = 8'h00
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       tick,
  input  logic [2:0] reg_addr,
  input  logic       reg_we,
  input  logic [7:0] reg_wdata,
  output logic [7:0] reg_rdata,
  input  logic       scl_in,
  input  logic       sda_in,
  output logic       scl_oe,
  output logic       sda_oe,
  output logic       irq
);

  localparam logic [7:0] C_START = 8'h08, C_RSTART = 8'h10;
  localparam logic [7:0] C_AW_ACK = 8'h18, C_AW_NAK = 8'h20;
  localparam logic [7:0] C_DW_ACK = 8'h28, C_DW_NAK = 8'h30;
  localparam logic [7:0] C_AR_ACK = 8'h40, C_AR_NAK = 8'h48;
  localparam logic [7:0] C_DR_ACK = 8'h50, C_DR_NAK = 8'h58;
  localparam logic [7:0] C_IDLE = 8'hF8;
  localparam logic [2:0] A_OWN = 3'd0, A_DATA = 3'd1, A_CTL = 3'd2,
                         A_STAT = 3'd3, A_BAUD = 3'd4, A_SRST = 3'd5;

  typedef enum logic [1:0] {S_IDLE, S_START, S_BYTE, S_STOP} st_t;

  st_t        st;
  logic [1:0] ph;
  logic [3:0] bc;
  logic [7:0] sh, data_q, status_q, baud_q, own_q;
  logic       ack_en, flag, stop_q, start_q, en, ie;
  logic       go, owned, addr_nx, dir, rx, ack_lat, nack;

  wire srst = reg_we && (reg_addr == A_SRST);
  wire hold = ((ph == 2'd2) && !scl_in) ||
              ((st == S_STOP) && (ph == 2'd3) && !(scl_in && sda_in));
  wire [7:0] ctl_rd = {ie, en, start_q, stop_q, flag, ack_en, 2'b00};

  logic [7:0] done_code;
  always_comb begin
    if (rx)           done_code = ack_lat ? C_DR_ACK : C_DR_NAK;
    else if (addr_nx) done_code = dir ? (nack ? C_AR_NAK : C_AR_ACK)
                                      : (nack ? C_AW_NAK : C_AW_ACK);
    else              done_code = nack ? C_DW_NAK : C_DW_ACK;
  end

  always_comb begin
    case (reg_addr)
      A_OWN:   reg_rdata = own_q;
      A_DATA:  reg_rdata = data_q;
      A_CTL:   reg_rdata = ctl_rd;
      A_STAT:  reg_rdata = status_q;
      A_BAUD:  reg_rdata = baud_q;
      default: reg_rdata = 8'h00;
    endcase
  end

  assign irq = flag & ie;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st <= S_IDLE; ph <= '0; bc <= '0; sh <= '0; data_q <= '0;
      status_q <= C_IDLE; baud_q <= BAUD_RST; own_q <= OWN_RST;
      ack_en <= 1'b0; flag <= 1'b0; stop_q <= 1'b0; start_q <= 1'b0;
      en <= 1'b0; ie <= 1'b0; go <= 1'b0; owned <= 1'b0; addr_nx <= 1'b0;
      dir <= 1'b0; rx <= 1'b0; ack_lat <= 1'b0; nack <= 1'b0;
      scl_oe <= 1'b0; sda_oe <= 1'b0;
    end else if (srst) begin
      st <= S_IDLE; ph <= '0; bc <= '0; sh <= '0; data_q <= '0;
      status_q <= C_IDLE; baud_q <= BAUD_RST; own_q <= OWN_RST;
      ack_en <= 1'b0; flag <= 1'b0; stop_q <= 1'b0; start_q <= 1'b0;
      en <= 1'b0; ie <= 1'b0; go <= 1'b0; owned <= 1'b0; addr_nx <= 1'b0;
      dir <= 1'b0; rx <= 1'b0; ack_lat <= 1'b0; nack <= 1'b0;
      scl_oe <= 1'b0; sda_oe <= 1'b0;
    end else begin
      if (reg_we) begin
        case (reg_addr)
          A_OWN:  own_q <= reg_wdata;
          A_DATA: data_q <= reg_wdata;
          A_CTL: begin
            ack_en  <= reg_wdata[2];
            flag    <= flag & reg_wdata[3];
            stop_q  <= reg_wdata[4];
            start_q <= reg_wdata[5];
            en      <= reg_wdata[6];
            ie      <= reg_wdata[7];
            go      <= flag & ~reg_wdata[3];
          end
          A_BAUD: baud_q <= reg_wdata;
          default: ;
        endcase
      end

      if (st == S_IDLE) begin
        ph <= '0;
        if (!flag && en) begin
          if (start_q) begin
            st <= S_START;
            go <= 1'b0;
          end else if (stop_q) begin
            go <= 1'b0;
            if (owned) st <= S_STOP;
            else stop_q <= 1'b0;
          end else if (go) begin
            go <= 1'b0;
            if (owned) begin
              st      <= S_BYTE;
              bc      <= '0;
              sh      <= data_q;
              dir     <= data_q[0];
              rx      <= (status_q == C_AR_ACK) || (status_q == C_DR_ACK);
              ack_lat <= ack_en;
            end
          end
        end
      end else if (tick && !hold) begin
        ph <= ph + 2'd1;
        case (st)
          S_START: case (ph)
            2'd0: sda_oe <= 1'b0;
            2'd1: scl_oe <= 1'b0;
            2'd2: sda_oe <= 1'b1;
            default: begin
              scl_oe   <= 1'b1;
              flag     <= 1'b1;
              status_q <= owned ? C_RSTART : C_START;
              owned    <= 1'b1;
              start_q  <= 1'b0;
              addr_nx  <= 1'b1;
              st       <= S_IDLE;
            end
          endcase
          S_BYTE: case (ph)
            2'd0: sda_oe <= (bc == 4'd8) ? (rx & ack_lat) : (~rx & ~sh[7]);
            2'd1: scl_oe <= 1'b0;
            2'd2: if (bc == 4'd8) nack <= sda_in;
                  else sh <= {sh[6:0], sda_in};
            default: begin
              scl_oe <= 1'b1;
              if (bc == 4'd8) begin
                flag     <= 1'b1;
                status_q <= done_code;
                if (rx) data_q <= sh;
                addr_nx  <= 1'b0;
                st       <= S_IDLE;
              end else begin
                bc <= bc + 4'd1;
              end
            end
          endcase
          S_STOP: case (ph)
            2'd0: sda_oe <= 1'b1;
            2'd1: scl_oe <= 1'b0;
            2'd2: sda_oe <= 1'b0;
            default: begin
              status_q <= C_IDLE;
              owned    <= 1'b0;
              stop_q   <= 1'b0;
              st       <= S_IDLE;
            end
          endcase
          default: st <= S_IDLE;
        endcase
      end
    end
  end

  // R6
  flag_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (flag && $past(flag)) |-> ($stable(scl_oe) && $stable(sda_oe)));

  // R6
  flag_code_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(flag) |-> (status_q != C_IDLE));

  // R9
  en_gate_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (st == S_IDLE && !en) |=> (st == S_IDLE));

  // R7
  stop_end_chk: assert property (@(posedge clk) disable iff (!rst_n)
    ($past(st) == S_STOP && st == S_IDLE) |-> (!flag && status_q == C_IDLE && !owned));

  // R11
  sda_edge_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (!scl_oe && !$past(scl_oe) && (sda_oe != $past(sda_oe)))
      |-> ($past(st) == S_START || $past(st) == S_STOP || $past(srst)));

endmodule

// File: tb/test_i2c_step_master.sv
module test_i2c_step_master;
  logic clk = 1'b0, rst_n = 1'b0;
  logic [1:0] tdiv = 2'd0;
  logic [2:0] reg_addr = 3'd0;
  logic reg_we = 1'b0;
  logic [7:0] reg_wdata = 8'h00, reg_rdata;
  logic scl_oe, sda_oe, irq, tick;
  logic s_low = 1'b0;
  wire scl_w = !scl_oe;
  wire sda_w = !(sda_oe || s_low);
  int nchk = 0, nfail = 0;
  int n_start = 0, n_stop = 0;

  always #5 clk = ~clk;
  always @(posedge clk) tdiv <= tdiv + 2'd1;
  assign tick = (tdiv == 2'd3);

  i2c_step_master i_i2c_step_master (
    .clk(clk), .rst_n(rst_n), .tick(tick), .reg_addr(reg_addr), .reg_we(reg_we),
    .reg_wdata(reg_wdata), .reg_rdata(reg_rdata), .scl_in(scl_w), .sda_in(sda_w),
    .scl_oe(scl_oe), .sda_oe(sda_oe), .irq(irq));

  // bus slave model at 7-bit address 0x50; NAKs written byte 0xEE
  logic pscl = 1'b1, psda = 1'b1;
  logic [7:0] s_sh = 8'h00, s_tx = 8'h00, s_nxt = 8'hA5, s_last = 8'h00;
  logic s_rw = 1'b0, s_skip = 1'b0, s_match = 1'b0, s_mack = 1'b0;
  int s_bc = 0, s_st = 0;
  always @(scl_w or sda_w) begin
    if (scl_w === 1'b1 && pscl === 1'b1 && sda_w !== psda) begin
      if (sda_w === 1'b0) begin s_st = 1; s_bc = 0; s_skip = 1'b1; n_start++; end
      else begin s_st = 0; n_stop++; end
      s_low = 1'b0;
    end else if (scl_w === 1'b1 && pscl === 1'b0) begin
      if ((s_st == 1 || s_st == 2) && s_bc < 8) s_sh = {s_sh[6:0], sda_w};
      else if (s_st == 3 && s_bc == 8) s_mack = !sda_w;
    end else if (scl_w === 1'b0 && pscl === 1'b1) begin
      if (s_skip) s_skip = 1'b0;
      else if (s_st != 0) begin
        if (s_bc < 7) begin
          s_bc++;
          if (s_st == 3) s_low = !s_tx[7 - s_bc];
        end else if (s_bc == 7) begin
          s_bc = 8;
          if (s_st == 1) begin
            s_match = (s_sh[7:1] == 7'h50); s_rw = s_sh[0]; s_low = s_match;
          end else if (s_st == 2) begin
            s_low = (s_sh != 8'hEE);
            if (s_sh != 8'hEE) s_last = s_sh;
          end else s_low = 1'b0;
        end else begin
          s_bc = 0; s_low = 1'b0;
          if (s_st == 1) begin
            if (!s_match) s_st = 0;
            else if (s_rw) begin s_st = 3; s_tx = s_nxt; s_nxt++; s_low = !s_tx[7]; end
            else s_st = 2;
          end else if (s_st == 3) begin
            if (s_mack) begin s_tx = s_nxt; s_nxt++; s_low = !s_tx[7]; end
            else s_st = 0;
          end
        end
      end
    end
    pscl = scl_w; psda = sda_w;
  end

  task automatic chk(input string req, input logic [7:0] act, input logic [7:0] exp);
    nchk++;
    if (act !== exp) begin
      nfail++;
      $display("FAIL %s actual=%02h expected=%02h", req, act, exp);
    end
  endtask

  task automatic wr(input logic [2:0] a, input logic [7:0] d);
    @(negedge clk); reg_addr = a; reg_wdata = d; reg_we = 1'b1;
    @(negedge clk); reg_we = 1'b0;
  endtask

  task automatic rd(input logic [2:0] a, output logic [7:0] v);
    @(negedge clk); reg_addr = a; #1 v = reg_rdata;
  endtask

  task automatic wait_flag(input string req);
    logic [7:0] v;
    for (int k = 0; k < 4000; k++) begin
      rd(3'd2, v);
      if (v[3]) return;
    end
    chk(req, 8'h00, 8'h08);
  endtask

  task automatic wait_idle(input string req);
    logic [7:0] v;
    for (int k = 0; k < 4000; k++) begin
      rd(3'd3, v);
      if (v == 8'hF8) return;
    end
    chk(req, v, 8'hF8);
  endtask

  task automatic finish_run;
    $display("== %0d vectors applied, %0d miscompares ==", nchk, nfail);
    $finish;
  endtask

  // {op, ack, byte, expected status, expected rx byte}; op 0 START 1 SEND 2 RECV 3 STOP
  localparam logic [31:0] VEC [0:17] = '{
    32'h0_0_00_08_00, 32'h1_0_A0_18_00, 32'h1_0_3C_28_00, 32'h1_0_EE_30_00,
    32'h3_0_00_F8_00, 32'h0_0_00_08_00, 32'h1_0_A0_18_00, 32'h1_0_11_28_00,
    32'h0_0_00_10_00, 32'h1_0_A1_40_00, 32'h2_1_00_50_A5, 32'h2_0_00_58_A6,
    32'h3_0_00_F8_00, 32'h0_0_00_08_00, 32'h1_0_B0_20_00, 32'h0_0_00_10_00,
    32'h1_0_B1_48_00, 32'h3_0_00_F8_00};

  initial begin
    repeat (150000) @(posedge clk);
    nfail++;
    $display("FAIL watchdog expired (run hung)");
    finish_run();
  end

  initial begin
    logic [7:0] v;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    // R1 reset state
    rd(3'd3, v); chk("R1 status", v, 8'hF8);
    rd(3'd2, v); chk("R1 control", v, 8'h00);
    rd(3'd4, v); chk("R1 baud", v, 8'h44);
    rd(3'd0, v); chk("R1 own addr", v, 8'h00);
    chk("R1 lines/irq", {5'd0, scl_oe, sda_oe, irq}, 8'h00);

    // R9 start request without enable
    wr(3'd2, 8'h20);
    repeat (100) @(negedge clk);
    rd(3'd3, v); chk("R9 status", v, 8'hF8);
    chk("R9 lines", {6'd0, scl_oe, sda_oe}, 8'h00);
    wr(3'd2, 8'h00);

    n_start = 0; n_stop = 0;
    for (int i = 0; i < 18; i++) begin
      logic [3:0] op;
      op = VEC[i][31:28];
      case (op)
        4'd0: begin wr(3'd2, 8'h60); wait_flag("R2 flag"); end
        4'd1: begin wr(3'd1, VEC[i][23:16]); wr(3'd2, 8'h40); wait_flag("R6 flag"); end
        4'd2: begin wr(3'd2, VEC[i][24] ? 8'h44 : 8'h40); wait_flag("R5 flag"); end
        default: begin wr(3'd2, 8'h50); wait_idle("R7 idle"); end
      endcase
      rd(3'd3, v);
      chk($sformatf("R2/R3/R4/R5/R7 vector %0d status", i), v, VEC[i][15:8]);
      if (op == 4'd2) begin
        rd(3'd1, v); chk($sformatf("R5 vector %0d rx byte", i), v, VEC[i][7:0]);
      end
      if (op == 4'd3) begin
        rd(3'd2, v); chk($sformatf("R7 vector %0d flag", i), {7'd0, v[3]}, 8'h00);
        chk("R7 lines released", {6'd0, scl_oe, sda_oe}, 8'h00);
      end
    end
    chk("R11 start edges", 8'(n_start), 8'd5);
    chk("R11 stop edges", 8'(n_stop), 8'd3);
    chk("R4 slave last byte", s_last, 8'h11);

    // R6 flag holds the bus; R8 irq gating
    wr(3'd2, 8'h60); wait_flag("R6 flag");
    wr(3'd1, 8'hA0);
    repeat (200) @(negedge clk);
    rd(3'd3, v); chk("R6 held status", v, 8'h08);
    chk("R6 scl held low", {7'd0, scl_oe}, 8'h01);
    chk("R8 irq off", {7'd0, irq}, 8'h00);
    wr(3'd2, 8'hC8);
    repeat (200) @(negedge clk);
    chk("R8 irq on", {7'd0, irq}, 8'h01);
    rd(3'd3, v); chk("R6 write one no launch", v, 8'h08);

    // R10 soft reset
    wr(3'd4, 8'h2B); wr(3'd0, 8'h12);
    rd(3'd4, v); chk("R10 baud written", v, 8'h2B);
    wr(3'd5, 8'h00);
    rd(3'd3, v); chk("R10 status", v, 8'hF8);
    rd(3'd2, v); chk("R10 control", v, 8'h00);
    rd(3'd4, v); chk("R10 baud", v, 8'h44);
    rd(3'd0, v); chk("R10 own addr", v, 8'h00);
    chk("R10 lines/irq", {5'd0, scl_oe, sda_oe, irq}, 8'h00);
    finish_run();
  end
endmodule